// File: doc/BRIEF.md
# Edge-Interrupt Pin Controller

This block is a memory-mapped controller for 28 general-purpose pins. It is reached over a plain 32-bit register bus. Each bus cycle carries a byte address, a write enable and write data, and the read data is returned in the same cycle. For every pin the block holds an output latch and a direction bit. It also samples the pin's input level through a two-stage synchronizer. Software changes the output latch only through two write-one-to-act registers, one that sets bits and one that clears them. This means no read-modify-write is ever needed to drive a single pin.

Every pin can watch for rising edges, falling edges or both, under two independent enable masks. A detected edge sets a sticky status bit, and software clears that bit by writing a one to it. Pins 0 to 10 each own an interrupt line that follows their status bit. Pins 11 to 27 share one line, which is the OR of their status bits. A further register is plain storage that holds a pin-function selection for neighbouring logic.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, direction, output latch, rising enables, falling enables, edge status and function storage are all zero, and every interrupt output is low.
- R2: A write to byte offset 0x08 sets every latch bit whose write-data bit is one and leaves the other bits unchanged. Reads of 0x08 return the latch, and `pinOut` equals the latch.
- R3: A write to byte offset 0x0C clears every latch bit whose write-data bit is one and leaves the other bits unchanged. Reads of 0x0C return the latch.
- R4: Offset 0x04 is a read/write direction mask, with 1 meaning output. `pinDir` equals this mask.
- R5: A read of offset 0x00 returns the pin inputs as they were two clock edges earlier. A pin change is not visible after only one edge.
- R6: A status bit becomes set in the third clock edge after a 0-to-1 pin change, provided that pin's bit at offset 0x10 is one. With the enable at zero, the change sets nothing.
- R7: A status bit becomes set in the third clock edge after a 1-to-0 pin change, provided that pin's bit at offset 0x14 is one. With both enables set, both edges are caught.
- R8: Writing to offset 0x18 clears each status bit whose write-data bit is one. Zero bits are ignored, and writing all ones clears every pending edge.
- R9: If a detected edge and a write-one-to-clear hit the same status bit in the same cycle, the bit stays set.
- R10: `irqPin[n]` equals status bit n for n from 0 to 10. `irqShared` is high exactly when any status bit from 11 to 27 is set.
- R11: Write-data bits 31 to 28 are dropped, and those bits always read as zero. Writes whose address bits 1:0 are not zero change nothing. Offset 0x1C holds whatever was written to it.
- R12: Reads never change state. Two back-to-back reads of the status register return the same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 5 | Byte address of the register |
| busWrEn | input | 1 | Write strobe for one cycle |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data of the addressed register, same cycle |
| pinIn | input | 28 | Raw asynchronous pin levels |
| pinOut | output | 28 | Output latch |
| pinDir | output | 28 | Direction mask, 1 means output |
| irqPin | output | 11 | Dedicated interrupt lines for pins 0 to 10 |
| irqShared | output | 1 | Combined interrupt line for pins 11 to 27 |

## Verification
The bench goes after the cycle in which a pin change becomes visible. A synchronizer one stage short would show the level and raise status one edge early. It also covers a clear that lands in the same cycle as a fresh edge: a design that gives priority to the clear would drop that event. Both polarities are tested separately and together, so swapped enable masks or a missing falling-edge path show up as wrong status bits. The shared line is tested with pins on both sides of bit 11, which catches a split in the wrong place. Misaligned and reserved-bit writes are also exercised.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  // Word index of each register (byte offset / 4); software depends on it.
  typedef enum logic [2:0] {
    SEL_LEVEL = 3'd0,
    SEL_DIR   = 3'd1,
    SEL_SET   = 3'd2,
    SEL_CLR   = 3'd3,
    SEL_RISE  = 3'd4,
    SEL_FALL  = 3'd5,
    SEL_STAT  = 3'd6,
    SEL_ALT   = 3'd7
  } regSelE;

  typedef struct packed {
    logic   wrDir;
    logic   wrSet;
    logic   wrClr;
    logic   wrRise;
    logic   wrFall;
    logic   wrAck;
    logic   wrAlt;
    regSelE rdSel;
  } ctlStrobesT;

endpackage

// File: rtl/gpio_edge_ctl.sv
module gpio_edge_ctl
  import gpio_edge_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output ctlStrobesT        stb
);

  localparam int WORD_LSB = 2;

  logic   aligned;
  logic   wrOk;
  regSelE sel;

  assign aligned = (busAddr[WORD_LSB-1:0] == '0);
  assign wrOk    = busWrEn && aligned;
  assign sel     = regSelE'(busAddr[WORD_LSB +: 3]);

  always_comb begin
    stb        = '0;
    stb.rdSel  = sel;
    stb.wrDir  = wrOk && (sel == SEL_DIR);
    stb.wrSet  = wrOk && (sel == SEL_SET);
    stb.wrClr  = wrOk && (sel == SEL_CLR);
    stb.wrRise = wrOk && (sel == SEL_RISE);
    stb.wrFall = wrOk && (sel == SEL_FALL);
    stb.wrAck  = wrOk && (sel == SEL_STAT);
    stb.wrAlt  = wrOk && (sel == SEL_ALT);
  end

endmodule

// File: rtl/gpio_edge_dp.sv
module gpio_edge_dp
  import gpio_edge_pkg::*;
#(
  parameter int NUM_PINS      = 28,
  parameter int NUM_DEDICATED = 11,
  parameter int DATA_W        = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctlStrobesT               stb,
  input  logic [NUM_PINS-1:0]      wrData,
  input  logic [NUM_PINS-1:0]      pinIn,
  output logic [DATA_W-1:0]        rdData,
  output logic [NUM_PINS-1:0]      pinOut,
  output logic [NUM_PINS-1:0]      pinDir,
  output logic [NUM_DEDICATED-1:0] irqPin,
  output logic                     irqShared
);

  localparam int PAD_W     = DATA_W - NUM_PINS;
  localparam int SHARED_LO = NUM_DEDICATED;

  logic [NUM_PINS-1:0] syncA, syncB, syncPrev;
  logic [NUM_PINS-1:0] dirReg, latchReg, riseEn, fallEn, statReg, altReg;
  logic [NUM_PINS-1:0] edgeHit;
  logic [NUM_PINS-1:0] ackMask;
  logic [NUM_PINS-1:0] rdSel;

  // Two-flop synchronizer plus one delayed copy for edge comparison
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= '0;
      syncB    <= '0;
      syncPrev <= '0;
    end else begin
      syncA    <= pinIn;
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end

  assign edgeHit = ((syncB & ~syncPrev) & riseEn) | ((~syncB & syncPrev) & fallEn);
  assign ackMask = stb.wrAck ? wrData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg   <= '0;
      latchReg <= '0;
      riseEn   <= '0;
      fallEn   <= '0;
      statReg  <= '0;
      altReg   <= '0;
    end else begin
      if (stb.wrDir)  dirReg <= wrData;
      if (stb.wrRise) riseEn <= wrData;
      if (stb.wrFall) fallEn <= wrData;
      if (stb.wrAlt)  altReg <= wrData;
      if (stb.wrSet)      latchReg <= latchReg | wrData;
      else if (stb.wrClr) latchReg <= latchReg & ~wrData;
      // A fresh edge wins over a simultaneous clear
      statReg <= (statReg & ~ackMask) | edgeHit;
    end
  end

  always_comb begin
    unique case (stb.rdSel)
      SEL_LEVEL: rdSel = syncB;
      SEL_DIR:   rdSel = dirReg;
      SEL_SET,
      SEL_CLR:   rdSel = latchReg;
      SEL_RISE:  rdSel = riseEn;
      SEL_FALL:  rdSel = fallEn;
      SEL_STAT:  rdSel = statReg;
      SEL_ALT:   rdSel = altReg;
      default:   rdSel = '0;
    endcase
  end

  assign rdData = {{PAD_W{1'b0}}, rdSel};
  assign pinOut = latchReg;
  assign pinDir = dirReg;

  for (genvar g = 0; g < NUM_DEDICATED; g++) begin : g_dedicated
    assign irqPin[g] = statReg[g];
  end
  assign irqShared = |statReg[NUM_PINS-1:SHARED_LO];

  // R2: set writes raise every addressed bit
  p_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrSet |=> ((latchReg & $past(wrData)) == $past(wrData)));

  // R2: without a set or clear strobe the latch holds
  p_latch_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.wrSet && !stb.wrClr) |=> $stable(latchReg));

  // R3: clear writes drop every addressed bit
  p_clr_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrClr |=> ((latchReg & $past(wrData)) == '0));

  // R4: direction register takes the written mask
  p_dir_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrDir |=> (dirReg == $past(wrData)));

  // R6: a status bit only turns on where an enabled edge was seen
  p_edge_src_r6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((statReg & ~$past(statReg)) & ~$past(edgeHit)) == '0));

  // R9: an edge coinciding with a clear is kept
  p_ack_keep_r9: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrAck |=> ((statReg & $past(edgeHit)) == $past(edgeHit)));

  // R10: the shared line can only rise after an edge on its pins
  p_shared_src_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqShared) |-> ($past(edgeHit[NUM_PINS-1:SHARED_LO]) != '0));

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter  int NUM_PINS      = 28,
  parameter  int NUM_DEDICATED = 11,
  parameter  int DATA_W        = 32,
  localparam int ADDR_W        = 5
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic                     busWrEn,
  input  logic [DATA_W-1:0]        busWrData,
  output logic [DATA_W-1:0]        busRdData,
  input  logic [NUM_PINS-1:0]      pinIn,
  output logic [NUM_PINS-1:0]      pinOut,
  output logic [NUM_PINS-1:0]      pinDir,
  output logic [NUM_DEDICATED-1:0] irqPin,
  output logic                     irqShared
);

  ctlStrobesT stb;
  logic       wrDataUnused;

  assign wrDataUnused = ^busWrData[DATA_W-1:NUM_PINS];

  gpio_edge_ctl #(.ADDR_W(ADDR_W)) i_ctl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .stb     (stb)
  );

  gpio_edge_dp #(
    .NUM_PINS      (NUM_PINS),
    .NUM_DEDICATED (NUM_DEDICATED),
    .DATA_W        (DATA_W)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrData    (busWrData[NUM_PINS-1:0]),
    .pinIn     (pinIn),
    .rdData    (busRdData),
    .pinOut    (pinOut),
    .pinDir    (pinDir),
    .irqPin    (irqPin),
    .irqShared (irqShared)
  );

endmodule

// File: tb/test_gpio_edge_ctrl.sv
`timescale 1ns/1ps
module test_gpio_edge_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [27:0] pinIn = '0;
  logic [27:0] pinOut, pinDir;
  logic [10:0] irqPin;
  logic        irqShared;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  gpio_edge_ctrl i_gpio_edge_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .pinIn(pinIn),
    .pinOut(pinOut), .pinDir(pinDir), .irqPin(irqPin), .irqShared(irqShared)
  );

  // Behavioural reference model
  logic [27:0] mDir, mLatch, mRise, mFall, mStat, mAlt;
  logic [27:0] hist[$] = '{28'd0, 28'd0, 28'd0};
  logic [27:0] mHit, mAck, wd;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mDir = '0; mLatch = '0; mRise = '0; mFall = '0; mStat = '0; mAlt = '0;
      hist = '{28'd0, 28'd0, 28'd0};
    end else begin
      wd   = busWrData[27:0];
      mHit = ((hist[1] & ~hist[2]) & mRise) | ((~hist[1] & hist[2]) & mFall);
      mAck = '0;
      if (busWrEn && busAddr[1:0] == 2'b00) begin
        case (busAddr[4:2])
          3'd1: mDir = wd;
          3'd2: mLatch = mLatch | wd;
          3'd3: mLatch = mLatch & ~wd;
          3'd4: mRise = wd;
          3'd5: mFall = wd;
          3'd6: mAck = wd;
          3'd7: mAlt = wd;
          default: ;
        endcase
      end
      mStat = (mStat & ~mAck) | mHit;
      hist = '{pinIn, hist[0], hist[1]};
    end
  end

  function automatic logic [31:0] expRd(input logic [4:0] a);
    case (a[4:2])
      3'd0: return {4'd0, hist[1]};
      3'd1: return {4'd0, mDir};
      3'd2, 3'd3: return {4'd0, mLatch};
      3'd4: return {4'd0, mRise};
      3'd5: return {4'd0, mFall};
      3'd6: return {4'd0, mStat};
      default: return {4'd0, mAlt};
    endcase
  endfunction

  function automatic string rdTag(input logic [4:0] a);
    case (a[4:2])
      3'd0: return "R5";
      3'd1: return "R4";
      3'd2: return "R2";
      3'd3: return "R3";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk(busRdData, expRd(busAddr), rdTag(busAddr));
      chk({4'd0, pinOut}, {4'd0, mLatch}, "R2 pinOut");
      chk({4'd0, pinDir}, {4'd0, mDir}, "R4 pinDir");
      chk({20'd0, irqShared, irqPin}, {20'd0, |mStat[27:11], mStat[10:0]}, "R10 irq");
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    step();
    busWrEn = 1'b0;
  endtask

  task automatic rdchk(input logic [4:0] a, input logic [31:0] exp, input string tag);
    busAddr = a; busWrEn = 1'b0;
    @(negedge clk);
    chk(busRdData, exp, tag);
    step();
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    step();

    // R1: reset state of every register and output
    for (int a = 0; a < 8; a++) rdchk(5'(a * 4), 32'h0, "R1");
    chk({19'd0, irqShared, irqPin, 1'b0}, 32'h0, "R1 irq");
    chk({4'd0, pinOut}, 32'h0, "R1 pinOut");

    // R4 / R11: direction mask, reserved bits dropped
    wr(5'h04, 32'hFFFF_FFFF);
    rdchk(5'h04, 32'h0FFF_FFFF, "R4 R11");
    chk({4'd0, pinDir}, 32'h0FFF_FFFF, "R4 pinDir");
    wr(5'h05, 32'h0);
    rdchk(5'h04, 32'h0FFF_FFFF, "R11 misaligned");

    // R2 / R3: set and clear registers
    wr(5'h08, 32'h0000_00F5);
    rdchk(5'h08, 32'h0000_00F5, "R2");
    wr(5'h08, 32'h0000_0100);
    rdchk(5'h08, 32'h0000_01F5, "R2");
    wr(5'h0C, 32'h0000_0005);
    rdchk(5'h0C, 32'h0000_01F0, "R3");
    chk({4'd0, pinOut}, 32'h0000_01F0, "R3 pinOut");

    // R5: level visible after two edges, not one
    pinIn = 28'h0ABCDEF;
    rdchk(5'h00, 32'h0, "R5 early");
    rdchk(5'h00, 32'h0, "R5 one edge");
    rdchk(5'h00, 32'h00AB_CDEF, "R5");
    pinIn = '0;
    repeat (4) step();
    rdchk(5'h18, 32'h0, "R6 no enable");

    // R6: rising detection on bits 0 and 12; bit 5 not enabled
    wr(5'h10, 32'h0000_1001);
    pinIn = 28'h0001021;
    repeat (4) step();
    rdchk(5'h18, 32'h0000_1001, "R6");
    chk({20'd0, irqShared, irqPin}, {20'd0, 1'b1, 11'h001}, "R10");

    // R7: falling detection on bits 0 and 5
    wr(5'h14, 32'h0000_0021);
    pinIn = '0;
    repeat (4) step();
    rdchk(5'h18, 32'h0000_1021, "R7");

    // R12: repeated reads change nothing
    rdchk(5'h18, 32'h0000_1021, "R12");
    rdchk(5'h18, 32'h0000_1021, "R12");

    // R8: clear only bit 12
    wr(5'h18, 32'h0000_1000);
    rdchk(5'h18, 32'h0000_0021, "R8");
    chk({20'd0, irqShared, irqPin}, {20'd0, 1'b0, 11'h021}, "R10");
    wr(5'h18, 32'hFFFF_FFFF);
    rdchk(5'h18, 32'h0, "R8 all");

    // R9: clear on bit 0 lands in the cycle its rising edge is detected
    pinIn = 28'h0000001;
    step();
    step();
    wr(5'h18, 32'h0000_0001);
    rdchk(5'h18, 32'h0000_0001, "R9");
    wr(5'h18, 32'h0000_0001);
    rdchk(5'h18, 32'h0, "R8 after R9");

    // R11: function storage
    wr(5'h1C, 32'hF000_00AB);
    rdchk(5'h1C, 32'h0000_00AB, "R11");

    // Random traffic, checked every clock against the model
    for (int i = 0; i < 3000; i++) begin
      pinIn ^= 28'($urandom & $urandom & $urandom);
      busAddr = 5'($urandom_range(0, 7) << 2);
      if ($urandom_range(0, 15) == 0) busAddr[0] = 1'b1;
      busWrData = $urandom;
      busWrEn = ($urandom_range(0, 2) == 0);
      step();
    end
    busWrEn = 1'b0;
    step();
    summary();
  end

endmodule